// File: doc/BRIEF.md
# Supply Monitor Boot and Sequence Controller

This block is the control state machine of a multichannel supply monitor. After a synchronous reset it decides from a stored run-at-power-on bit whether to start the self-test engine. It then asks the nonvolatile configuration store for its contents and captures them. Only after both steps does it open the host register port and allow the active-low interrupt output to assert. Each load result arrives with single-error-correct, double-error-detect status. If the load reports an uncorrectable error, the block falls back to built-in default configuration values.

Once the block is enabled, it watches two asynchronous control inputs, ACT and SLEEP. A rising ACT edge loads a programmable timeout counter and marks the power-up sequence as being monitored. When the counter runs out, an expiry indication is raised. SLEEP edges are acted on only while ACT is high and that indication is set. A falling SLEEP edge produces a sleep-entry event pulse and a rising edge produces a sleep-exit event pulse.

Three sticky interrupt flags record self-test completion, a corrected ECC error and an uncorrectable ECC error. Each flag is cleared by writing 1 to it and has its own interrupt-enable bit.

Top module: `supmon_ctrl`

## Requirements
- R1: Out of reset, the block asserts `bist_start_o` only when `cfg_run_bist_i` is 1. When that input is 0, it goes directly to asserting `cfg_req_o` and never raises `bist_start_o`.
- R2: `host_en_o` stays 0 and `irq_n_o` stays 1 until the configuration load has been acknowledged by `cfg_done_i`. This holds through the whole self-test step.
- R3: When a load completes, `test_info_o` holds the following fields: bit0 = self-test ran, bit1 = self-test passed, bit2 = corrected error, bit3 = uncorrectable error. `cfg_o` takes `cfg_data_i`, or the parameter `CFG_DEFAULT` when `cfg_ded_i` was 1.
- R4: Once enabled, an ACT rising edge behaves as follows. The edge is seen three clocks after it appears at the port. It sets `seq_active_o` and clears `seq_expired_o`. `seq_expired_o` rises exactly `seq_timeout_i` clocks later (minimum 1) and stays 1 until the next ACT rising edge, whatever level ACT has meanwhile.
- R5: SLEEP edges produce no event pulse unless ACT is high and `seq_expired_o` is 1.
- R6: When the condition in R5 holds, a SLEEP 1→0 edge gives a one-cycle `sleep_entry_o` pulse and a 0→1 edge gives a one-cycle `sleep_exit_o` pulse.
- R7: Self-test completion sets flag bit0 of `flags_o`. `irq_n_o` goes low for this flag only when `irq_en_i[0]` is 1.
- R8: `bist_done_o` reads 1 from the clock in which the self-test step completes, and stays 1 until reset.
- R9: The flags are bit0 self-test complete, bit1 corrected error and bit2 uncorrectable error. Each flag is sticky and is cleared by a 1 on the matching `flag_clr_i` bit. A set event in the same clock wins over a clear. Once enabled, `irq_n_o` is low exactly when some flag is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_run_bist_i | input | 1 | Stored bit: run the self-test after reset |
| bist_start_o | output | 1 | Self-test request, held until done |
| bist_done_i | input | 1 | One-cycle self-test completion strobe |
| bist_pass_i | input | 1 | Self-test result, valid with done |
| cfg_req_o | output | 1 | Configuration load request, held until done |
| cfg_done_i | input | 1 | One-cycle load completion strobe |
| cfg_sec_i | input | 1 | Load had a corrected single-bit error |
| cfg_ded_i | input | 1 | Load had an uncorrectable double-bit error |
| cfg_data_i | input | CFG_W | Loaded configuration word |
| cfg_o | output | CFG_W | Active configuration |
| test_info_o | output | 4 | Self-test and ECC outcome (R3) |
| bist_done_o | output | 1 | Live self-test-complete status |
| host_en_o | output | 1 | Host register port enabled |
| act_i | input | 1 | Asynchronous ACT control input |
| sleep_i | input | 1 | Asynchronous SLEEP control input |
| seq_timeout_i | input | TMR_W | Sequence timeout in clocks |
| seq_active_o | output | 1 | Timeout counter running |
| seq_expired_o | output | 1 | Timeout elapsed since last ACT rise |
| sleep_entry_o | output | 1 | Sleep-entry event pulse |
| sleep_exit_o | output | 1 | Sleep-exit event pulse |
| irq_en_i | input | 3 | Per-flag interrupt enables |
| flag_clr_i | input | 3 | Write-1-to-clear strobes for the flags |
| flags_o | output | 3 | Sticky interrupt flags |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The assertions assume the following of the inputs. `bist_done_i` and `cfg_done_i` are single-cycle strobes that arrive only while the matching request is high. `seq_timeout_i` does not change while the counter runs. ACT and SLEEP may change at any time, since they pass through synchronizers. The bench keeps to these rules. It answers each request with one strobe after a short delay, holds the timeout value steady for the whole run, and drives ACT and SLEEP shortly after a clock edge. Under those conditions a behavioural model in the bench predicts every compared output on each clock.

// File: rtl/supmon_pkg.sv
// Shared types and flag positions for the supply-monitor controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package supmon_pkg;

    typedef enum logic [1:0] {
        BT_IDLE     = 2'd0,
        BT_SELFTEST = 2'd1,
        BT_LOAD     = 2'd2,
        BT_READY    = 2'd3
    } boot_st_e;

    localparam int NUM_FLAGS = 3;
    localparam int FLAG_BIST = 0;
    localparam int FLAG_SEC  = 1;
    localparam int FLAG_DED  = 2;

    typedef struct packed {
        logic ded;
        logic sec;
        logic pass;
        logic ran;
    } test_info_t;

endpackage

// File: rtl/supmon_sync_edge.sv
// Multi-stage synchronizer followed by an edge detector.
// Assumes d_i is asynchronous to clk; rise/fall are single-cycle pulses
// derived from the synchronized level and its one-cycle-old copy.
module supmon_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] shreg;
    logic         prev;

    // Shift the asynchronous input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            prev  <= 1'b0;
        end else begin
            shreg <= {shreg[TOP-1:0], d_i};
            prev  <= shreg[TOP];
        end
    end

    // Derive level and edges from the synchronized stage.
    always_comb begin
        level_o = shreg[TOP];
        rise_o  = shreg[TOP] & ~prev;
        fall_o  = ~shreg[TOP] & prev;
    end

    a_r6_edges_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o));

endmodule

// File: rtl/supmon_boot.sv
// Power-up sequencer: optional self-test, then configuration load.
// Assumes bist_done_i / cfg_done_i are single-cycle strobes given only
// while the matching request is asserted. Emits one-cycle flag set events.
module supmon_boot
    import supmon_pkg::*;
#(
    parameter int             CFG_W       = 16,
    parameter logic [CFG_W-1:0] CFG_DEFAULT = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_bist_i,
    input  logic                 bist_done_i,
    input  logic                 bist_pass_i,
    input  logic                 cfg_done_i,
    input  logic                 cfg_sec_i,
    input  logic                 cfg_ded_i,
    input  logic [CFG_W-1:0]     cfg_data_i,
    output logic                 bist_start_o,
    output logic                 cfg_req_o,
    output logic                 host_en_o,
    output logic                 bist_cmpl_o,
    output test_info_t           info_o,
    output logic [CFG_W-1:0]     cfg_o,
    output logic [NUM_FLAGS-1:0] set_o
);
    boot_st_e   st, st_nxt;
    logic       bist_fin, load_fin;
    test_info_t info_q;
    logic       cmpl_q;
    logic [CFG_W-1:0] cfg_q;

    // Completion events of each boot step.
    always_comb begin
        bist_fin = (st == BT_SELFTEST) && bist_done_i;
        load_fin = (st == BT_LOAD) && cfg_done_i;
    end

    // Next-state selection of the boot sequence.
    always_comb begin
        st_nxt = st;
        unique case (st)
            BT_IDLE:     st_nxt = run_bist_i ? BT_SELFTEST : BT_LOAD;
            BT_SELFTEST: if (bist_fin) st_nxt = BT_LOAD;
            BT_LOAD:     if (load_fin) st_nxt = BT_READY;
            BT_READY:    st_nxt = BT_READY;
            default:     st_nxt = BT_IDLE;
        endcase
    end

    // State register plus captured test outcome and configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= BT_IDLE;
            info_q <= '0;
            cmpl_q <= 1'b0;
            cfg_q  <= CFG_DEFAULT;
        end else begin
            st <= st_nxt;
            if (bist_fin) begin
                cmpl_q      <= 1'b1;
                info_q.ran  <= 1'b1;
                info_q.pass <= bist_pass_i;
            end
            if (load_fin) begin
                info_q.sec <= cfg_sec_i;
                info_q.ded <= cfg_ded_i;
                cfg_q      <= cfg_ded_i ? CFG_DEFAULT : cfg_data_i;
            end
        end
    end

    // Decode outputs and flag set events.
    always_comb begin
        bist_start_o        = (st == BT_SELFTEST);
        cfg_req_o           = (st == BT_LOAD);
        host_en_o           = (st == BT_READY);
        bist_cmpl_o         = cmpl_q;
        info_o              = info_q;
        cfg_o               = cfg_q;
        set_o               = '0;
        set_o[FLAG_BIST]    = bist_fin;
        set_o[FLAG_SEC]     = load_fin && cfg_sec_i;
        set_o[FLAG_DED]     = load_fin && cfg_ded_i;
    end

    a_r1_skip_selftest : assert property (@(posedge clk) disable iff (!rst_n)
        (st == BT_IDLE && !run_bist_i) |=> !bist_start_o);
    a_r2_enable_after_load : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_en_o) |-> $past(cfg_done_i));
    a_r8_cmpl_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        bist_cmpl_o |=> bist_cmpl_o);

endmodule

// File: rtl/supmon_seq.sv
// Sequence-timeout tracker and SLEEP event gate.
// Assumes en_i marks the enabled state; timeout value is held stable while
// the counter runs. Expiry persists until the next qualifying ACT rise.
module supmon_seq #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             act_level_i,
    input  logic             act_rise_i,
    input  logic             sleep_rise_i,
    input  logic             sleep_fall_i,
    input  logic [TMR_W-1:0] timeout_i,
    output logic             active_o,
    output logic             expired_o,
    output logic             entry_o,
    output logic             exit_o
);
    localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

    logic [TMR_W-1:0] cnt;
    logic             running, expired;
    logic             window;

    // Load on ACT rise, count down, flag expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
            expired <= 1'b0;
        end else if (en_i && act_rise_i) begin
            cnt     <= timeout_i;
            running <= 1'b1;
            expired <= 1'b0;
        end else if (running) begin
            if (cnt <= ONE) begin
                running <= 1'b0;
                expired <= 1'b1;
            end else begin
                cnt <= cnt - ONE;
            end
        end
    end

    // Gate SLEEP edges by ACT level and expiry.
    always_comb begin
        window    = en_i && act_level_i && expired;
        entry_o   = window && sleep_fall_i;
        exit_o    = window && sleep_rise_i;
        active_o  = running;
        expired_o = expired;
    end

    a_r4_arm_on_rise : assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && act_rise_i) |=> (active_o && !expired_o));
    a_r4_expiry_holds : assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !act_rise_i) |=> expired_o);
    a_r6_entry_single : assert property (@(posedge clk) disable iff (!rst_n)
        entry_o |=> !entry_o);
    a_r5_one_event : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({entry_o, exit_o}));

endmodule

// File: rtl/supmon_ctrl.sv
// Top of the supply-monitor control block: boot sequencer, input
// synchronizers, sequence tracker and sticky interrupt flags.
// Assumes synchronous active-low reset and single-cycle done strobes.
module supmon_ctrl
    import supmon_pkg::*;
#(
    parameter int               CFG_W       = 16,
    parameter logic [CFG_W-1:0] CFG_DEFAULT = 16'h00A5,
    parameter int               TMR_W       = 16,
    parameter int               SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_run_bist_i,
    output logic                 bist_start_o,
    input  logic                 bist_done_i,
    input  logic                 bist_pass_i,
    output logic                 cfg_req_o,
    input  logic                 cfg_done_i,
    input  logic                 cfg_sec_i,
    input  logic                 cfg_ded_i,
    input  logic [CFG_W-1:0]     cfg_data_i,
    output logic [CFG_W-1:0]     cfg_o,
    output logic [3:0]           test_info_o,
    output logic                 bist_done_o,
    output logic                 host_en_o,
    input  logic                 act_i,
    input  logic                 sleep_i,
    input  logic [TMR_W-1:0]     seq_timeout_i,
    output logic                 seq_active_o,
    output logic                 seq_expired_o,
    output logic                 sleep_entry_o,
    output logic                 sleep_exit_o,
    input  logic [NUM_FLAGS-1:0] irq_en_i,
    input  logic [NUM_FLAGS-1:0] flag_clr_i,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic                 irq_n_o
);
    logic [NUM_FLAGS-1:0] set_ev;
    logic [NUM_FLAGS-1:0] flags_q;
    test_info_t           info;
    logic act_lvl, act_rise, act_fall;
    logic slp_lvl, slp_rise, slp_fall;

    supmon_boot #(.CFG_W(CFG_W), .CFG_DEFAULT(CFG_DEFAULT)) u_boot (
        .clk(clk), .rst_n(rst_n), .run_bist_i(cfg_run_bist_i),
        .bist_done_i(bist_done_i), .bist_pass_i(bist_pass_i),
        .cfg_done_i(cfg_done_i), .cfg_sec_i(cfg_sec_i), .cfg_ded_i(cfg_ded_i),
        .cfg_data_i(cfg_data_i), .bist_start_o(bist_start_o),
        .cfg_req_o(cfg_req_o), .host_en_o(host_en_o),
        .bist_cmpl_o(bist_done_o), .info_o(info), .cfg_o(cfg_o),
        .set_o(set_ev)
    );

    supmon_sync_edge #(.STAGES(SYNC_STAGES)) u_act_sync (
        .clk(clk), .rst_n(rst_n), .d_i(act_i),
        .level_o(act_lvl), .rise_o(act_rise), .fall_o(act_fall)
    );

    supmon_sync_edge #(.STAGES(SYNC_STAGES)) u_slp_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sleep_i),
        .level_o(slp_lvl), .rise_o(slp_rise), .fall_o(slp_fall)
    );

    supmon_seq #(.TMR_W(TMR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en_i(host_en_o),
        .act_level_i(act_lvl), .act_rise_i(act_rise),
        .sleep_rise_i(slp_rise), .sleep_fall_i(slp_fall),
        .timeout_i(seq_timeout_i), .active_o(seq_active_o),
        .expired_o(seq_expired_o), .entry_o(sleep_entry_o),
        .exit_o(sleep_exit_o)
    );

    // One sticky write-1-to-clear flag per event; set wins over clear.
    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)          flags_q[gi] <= 1'b0;
            else if (set_ev[gi]) flags_q[gi] <= 1'b1;
            else if (flag_clr_i[gi]) flags_q[gi] <= 1'b0;
        end

        a_r9_flag_sticky : assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[gi] && !flag_clr_i[gi]) |=> flags_o[gi]);
        a_r9_clear_takes : assert property (@(posedge clk) disable iff (!rst_n)
            (flag_clr_i[gi] && !set_ev[gi]) |=> !flags_o[gi]);
    end

    // Outputs: flags, test info, and the gated active-low interrupt.
    always_comb begin
        flags_o     = flags_q;
        test_info_o = info;
        irq_n_o     = ~(host_en_o && |(flags_q & irq_en_i));
    end

    a_r7_bist_sets_flag : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bist_done_o) |-> flags_o[FLAG_BIST]);
    a_r2_no_irq_in_boot : assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req_o || bist_start_o) |-> irq_n_o);

endmodule

// File: tb/sim_supmon_ctrl.sv
module sim_supmon_ctrl;
    localparam int CFG_W = 16;
    localparam logic [CFG_W-1:0] DEF = 16'h00A5;
    localparam int TMR_W = 16;
    localparam int TOUT = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_bist = 1'b1, bdone = 1'b0, bpass = 1'b0;
    logic cdone = 1'b0, csec = 1'b0, cded = 1'b0;
    logic [CFG_W-1:0] cdata = '0;
    logic act = 1'b0, slp = 1'b1;
    logic [TMR_W-1:0] tout = TMR_W'(TOUT);
    logic [2:0] ien = '0, clr = '0;
    logic bstart, creq, hen, bdo, sact, sexp, sent, sext, irqn;
    logic [CFG_W-1:0] cfg;
    logic [3:0] tinfo;
    logic [2:0] flags;

    int checks = 0, errors = 0;
    int n_entry = 0, n_exit = 0, n_start = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    supmon_ctrl #(.CFG_W(CFG_W), .CFG_DEFAULT(DEF), .TMR_W(TMR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_run_bist_i(run_bist),
        .bist_start_o(bstart), .bist_done_i(bdone), .bist_pass_i(bpass),
        .cfg_req_o(creq), .cfg_done_i(cdone), .cfg_sec_i(csec),
        .cfg_ded_i(cded), .cfg_data_i(cdata), .cfg_o(cfg),
        .test_info_o(tinfo), .bist_done_o(bdo), .host_en_o(hen),
        .act_i(act), .sleep_i(slp), .seq_timeout_i(tout),
        .seq_active_o(sact), .seq_expired_o(sexp),
        .sleep_entry_o(sent), .sleep_exit_o(sext),
        .irq_en_i(ien), .flag_clr_i(clr), .flags_o(flags), .irq_n_o(irqn)
    );

    task automatic chk(input string tag, input longint act_v, input longint exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Behavioural reference model: boot phase, flags, timer, delayed inputs.
    int  m_phase;
    bit  m_cmpl;
    bit [2:0] m_flags;
    int  m_left;
    bit  m_run, m_exp;
    bit  a_hist[$], s_hist[$];

    function automatic bit hist(ref bit q[$], input int age);
        return (q.size() > age) ? q[q.size()-1-age] : 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cmpl = 0; m_flags = '0;
            m_left = 0; m_run = 0; m_exp = 0;
            a_hist.delete(); s_hist.delete();
        end else begin
            bit ready, arise;
            bit [2:0] setv;
            ready = (m_phase == 3);
            arise = hist(a_hist, 1) && !hist(a_hist, 2);
            setv = '0;
            if (m_phase == 0) m_phase = run_bist ? 1 : 2;
            else if (m_phase == 1 && bdone) begin m_phase = 2; m_cmpl = 1; setv[0] = 1; end
            else if (m_phase == 2 && cdone) begin m_phase = 3; setv[1] = csec; setv[2] = cded; end
            m_flags = (m_flags & ~clr) | setv;
            if (ready && arise) begin
                m_left = int'(tout); m_run = 1; m_exp = 0;
            end else if (m_run) begin
                if (m_left <= 1) begin m_run = 0; m_exp = 1; end
                else m_left--;
            end
            a_hist.push_back(act);
            s_hist.push_back(slp);
            if (a_hist.size() > 4) void'(a_hist.pop_front());
            if (s_hist.size() > 4) void'(s_hist.pop_front());
        end
    end

    // Compare every clock on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit win;
            win = (m_phase == 3) && hist(a_hist, 1) && m_exp;
            chk("R1 model bist_start", bstart, m_phase == 1);
            chk("R2 model host_en", hen, m_phase == 3);
            chk("R2 model cfg_req", creq, m_phase == 2);
            chk("R8 model bist_done", bdo, m_cmpl);
            chk("R9 model flags", flags, m_flags);
            chk("R9 model irq_n", irqn, !((m_phase == 3) && |(m_flags & ien)));
            chk("R4 model expired", sexp, m_exp);
            chk("R4 model active", sact, m_run);
            chk("R6 model entry", sent, win && !hist(s_hist, 1) && hist(s_hist, 2));
            chk("R6 model exit", sext, win && hist(s_hist, 1) && !hist(s_hist, 2));
        end
        if (sent) n_entry++;
        if (sext) n_exit++;
        if (bstart) n_start++;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cyc;
        // Boot with self-test enabled.
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset host_en", hen, 0);
        chk("R2 reset irq_n", irqn, 1);
        chk("R9 reset flags", flags, 0);
        step(1);
        chk("R1 bist_start asserted", bstart, 1);
        chk("R2 cfg_req idle in selftest", creq, 0);
        step(3);
        bdone = 1; bpass = 1;
        step(1);
        bdone = 0;
        chk("R8 bist_done live", bdo, 1);
        chk("R7 flag set", flags, 3'b001);
        chk("R2 irq held during load", irqn, 1);
        ien = 3'b001;
        step(2);
        chk("R2 irq held with enable", irqn, 1);
        csec = 1; cdata = 16'h1234; cdone = 1;
        step(1);
        cdone = 0; csec = 0;
        chk("R2 host enabled", hen, 1);
        chk("R3 cfg captured", cfg, 16'h1234);
        chk("R3 test info", tinfo, 4'b0111);
        chk("R9 sec flag", flags, 3'b011);
        chk("R7 irq asserted", irqn, 0);
        ien = 3'b000; #1;
        chk("R7 irq masked", irqn, 1);
        ien = 3'b010; #1;
        chk("R9 irq from sec", irqn, 0);
        clr = 3'b010;
        step(1);
        clr = 3'b000;
        chk("R9 w1c sec", flags, 3'b001);
        chk("R9 irq dropped", irqn, 1);
        clr = 3'b001;
        step(1);
        clr = 3'b000;
        chk("R9 w1c bist", flags, 3'b000);
        // SLEEP toggles before any ACT edge.
        slp = 0; step(6); slp = 1; step(6);
        chk("R5 no event before act", n_entry + n_exit, 0);
        // ACT rise and timeout window.
        act = 1;
        step(1);
        slp = 0;
        cyc = 1;
        while (!sexp && cyc < 200) begin step(1); cyc++; end
        chk("R4 expiry latency", cyc, 3 + TOUT);
        chk("R5 no event in window", n_entry + n_exit, 0);
        slp = 1; step(6);
        chk("R6 exit pulse", n_exit, 1);
        slp = 0; step(6);
        chk("R6 entry pulse", n_entry, 1);
        act = 0; step(8);
        chk("R4 expiry persists", sexp, 1);
        slp = 1; step(6); slp = 0; step(6);
        chk("R5 act low blocks", n_entry + n_exit, 2);
        // Second boot: self-test skipped, uncorrectable load.
        rst_n = 0; run_bist = 0; slp = 1;
        step(2);
        n_start = 0;
        rst_n = 1;
        step(1);
        chk("R1 load requested directly", creq, 1);
        step(2);
        cded = 1; cdata = 16'hBEEF; cdone = 1; clr = 3'b111;
        step(1);
        cdone = 0; cded = 0; clr = 3'b000;
        chk("R1 no selftest started", n_start, 0);
        chk("R3 default config", cfg, DEF);
        chk("R3 ded info", tinfo, 4'b1000);
        chk("R9 set beats clear", flags, 3'b100);
        chk("R8 bist_done clear when skipped", bdo, 0);
        step(2);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule